// File: doc/BRIEF.md
# Timer Capture/Compare Option and Overflow Register

This block is the 8-bit option register of a 16-bit up-counting timer that has two capture/compare channels. It stores one select bit per channel. Each bit decides whether that channel works as a compare register or as a capture register. The select only takes effect while the timer runs in its free-running mode. In every other mode both channels report compare.

The block also watches the counter value for a wrap from 0xFFFF to 0x0000. It does this only in the free-running and pulse-width-measurement modes. On a wrap it raises a sticky overflow flag and emits a one-cycle interrupt pulse in the same cycle.

Software reaches the register through a plain byte bus:
- A whole-byte write strobe.
- A single-bit write port that names one bit by index.
- A read strobe that returns the register image without side effects.

The timer core supplies the counter enable, the operating mode code and the live count. It consumes the effective per-channel selects, the flag and the pulse. No data stream crosses this block, so every pin is a plain level or strobe with no handshake.

Top module: `tmr_optreg`

## Requirements
- R1: After reset the register image is 0x00: `rd_data` reads 0x00, `ovf_flag`=0, `ovf_irq`=0 and `ch_capture`=0.
- R2: The register image places the overflow flag at bit 0, the channel 0 select at bit 4 and the channel 1 select at bit 5. Bits 1-3, 6 and 7 always read 0, and writes to them are discarded.
- R2 (read port): `rd_data` shows the register image while `rd_en`=1 and reads 0x00 while `rd_en`=0.
- R3: `ch_capture[i]`=1 means capture and 0 means compare. It equals the stored select bit only while `mode`=3'b101 (free-running). For any other mode code it is 0.
- R4: While `cnt_en`=1, writes to the select bits are ignored and the stored selects keep their values. While `cnt_en`=0 they are writable.
- R5: With `cnt_en`=1 and `mode` equal to 3'b101 or 3'b110 (pulse-width measurement), a `count` of 0x0000 in the cycle after a `count` of 0xFFFF has two effects after the next clock edge. `ovf_flag` becomes 1, and `ovf_irq` is 1 for exactly that one cycle.
- R6: In any mode code other than 3'b101 or 3'b110, a wrap neither sets the flag nor pulses `ovf_irq`.
- R7: Reading the register, whether the flag alone or the whole byte, never clears the flag.
- R8: Writing 0 to bit 0 clears the flag at the next edge. Writing 1 to bit 0 has no effect, so software can never set the flag.
- R9: A cycle with `cnt_en`=0 clears the flag at the next edge.
- R10: If a wrap and a software clear of the flag fall in the same cycle, the flag ends at 1 and the pulse is still issued.
- R11: A single-bit write changes only the bit named by `bit_wr_idx`. If the byte strobe and the bit strobe are both active in one cycle, the byte write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Whole-byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_wr_idx | input | 3 | Index of the bit to write |
| bit_wr_val | input | 1 | Value for the single-bit write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Register image while `rd_en`=1, else 0x00 |
| cnt_en | input | 1 | Counter enable from the timer core |
| mode | input | 3 | Timer operating mode code |
| count | input | 16 | Live counter value |
| ch_capture | output | 2 | Effective per-channel select (1 = capture) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
Two functions can land in the same cycle: the counter wrap that sets the flag, and a software write of 0 that clears it. A wrap can also meet a counter disable. The bench provokes the write collision directly: it drives the 0xFFFF-to-0x0000 step together with a zero write to bit 0, once through the byte port and once through the single-bit port. It expects the flag to stay 1 with the pulse present. The random phase pushes the count toward 0xFFFF often while writes and enable drops arrive at random. In that phase every cycle is judged against a bench model that applies the order disable, then wrap, then clear.

// File: rtl/tmr_opt_pkg.sv
package tmr_opt_pkg;
  localparam int REG_W  = 8;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 3;
  localparam int NUM_CH = 2;
  localparam int IDX_W  = $clog2(REG_W);

  localparam int FLAG_BIT = 0;
  localparam int SEL_LSB  = 4;

  localparam logic [MODE_W-1:0] MODE_FREERUN = 3'b101;
  localparam logic [MODE_W-1:0] MODE_PWIDTH  = 3'b110;

  localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(1) << FLAG_BIT;
  localparam logic [REG_W-1:0] SEL_MASK  = REG_W'((1 << NUM_CH) - 1) << SEL_LSB;
endpackage

// File: rtl/tmr_wrap_detect.sv
module tmr_wrap_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             mode_ok,
  input  logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] prev_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_cnt <= '0;
    else        prev_cnt <= count;
  end

  assign wrap = cnt_en && mode_ok && (prev_cnt == CNT_MAX) && (count == '0);
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic wrap,
  input  logic sw_clr,
  output logic flag,
  output logic irq
);
  logic flag_nx;

  always_comb begin
    flag_nx = flag;
    if (!cnt_en)     flag_nx = 1'b0;
    else if (wrap)   flag_nx = 1'b1;
    else if (sw_clr) flag_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nx;
      irq  <= wrap;
    end
  end
endmodule

// File: rtl/tmr_ccsel.sv
module tmr_ccsel #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              freerun,
  input  logic [NUM_CH-1:0] wr_hit,
  input  logic [NUM_CH-1:0] wr_val,
  output logic [NUM_CH-1:0] sel_raw,
  output logic [NUM_CH-1:0] ch_capture
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sel_raw[i] <= 1'b0;
      else if (!cnt_en && wr_hit[i]) sel_raw[i] <= wr_val[i];
    end
    assign ch_capture[i] = freerun & sel_raw[i];
  end
endmodule

// File: rtl/tmr_optreg.sv
module tmr_optreg
  import tmr_opt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              bit_wr_en,
  input  logic [IDX_W-1:0]  bit_wr_idx,
  input  logic              bit_wr_val,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  input  logic              cnt_en,
  input  logic [MODE_W-1:0] mode,
  input  logic [CW-1:0]     count,
  output logic [NUM_CH-1:0] ch_capture,
  output logic              ovf_flag,
  output logic              ovf_irq
);
  localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(FLAG_BIT);

  logic              freerun;
  logic              mode_ok;
  logic              wrap;
  logic              sw_clr;
  logic              byte_flag;
  logic [NUM_CH-1:0] byte_sel;
  logic [NUM_CH-1:0] sel_hit;
  logic [NUM_CH-1:0] sel_val;
  logic [NUM_CH-1:0] sel_raw;

  assign freerun = (mode == MODE_FREERUN);
  assign mode_ok = freerun || (mode == MODE_PWIDTH);

  // Only the kept fields of a byte write are extracted; reserved bits drop out.
  assign byte_flag = |(wr_data & FLAG_MASK);
  assign byte_sel  = NUM_CH'((wr_data & SEL_MASK) >> SEL_LSB);

  // Byte strobe has priority over the single-bit strobe.
  assign sw_clr = wr_en ? !byte_flag
                        : (bit_wr_en && (bit_wr_idx == FLAG_IDX) && !bit_wr_val);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(SEL_LSB + i);
    assign sel_hit[i] = wr_en || (bit_wr_en && (bit_wr_idx == SEL_IDX));
    assign sel_val[i] = wr_en ? byte_sel[i] : bit_wr_val;
  end

  tmr_wrap_detect #(.CNT_W(CW)) u_wrap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .mode_ok (mode_ok),
    .count   (count),
    .wrap    (wrap)
  );

  tmr_ovf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .wrap   (wrap),
    .sw_clr (sw_clr),
    .flag   (ovf_flag),
    .irq    (ovf_irq)
  );

  tmr_ccsel #(.NUM_CH(NUM_CH)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .freerun    (freerun),
    .wr_hit     (sel_hit),
    .wr_val     (sel_val),
    .sel_raw    (sel_raw),
    .ch_capture (ch_capture)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      rd_data[FLAG_BIT] = ovf_flag;
      rd_data[SEL_LSB +: NUM_CH] = sel_raw;
    end
  end
endmodule

// File: rtl/tmr_optreg_chk.sv
module tmr_optreg_chk
  import tmr_opt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [REG_W-1:0]  rd_data,
  input logic              cnt_en,
  input logic [MODE_W-1:0] mode,
  input logic [NUM_CH-1:0] ch_capture,
  input logic              ovf_flag,
  input logic              ovf_irq
);
  localparam logic [REG_W-1:0] KEEP = FLAG_MASK | SEL_MASK;

  always_comb begin
    if (rst_n) AST_RSV_READ_ZERO: assert ((rd_data & ~KEEP) == '0); // R2
  end

  AST_IRQ_ONLY_TWO_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ($past(cnt_en) && ($past(mode) == MODE_FREERUN || $past(mode) == MODE_PWIDTH))); // R6

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag); // R5

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq); // R5

  AST_FLAG_RISE_BY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ovf_irq); // R8

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> !ovf_flag); // R9

  AST_SEL_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && mode == MODE_FREERUN) |=> (cnt_en && mode == MODE_FREERUN) -> $stable(ch_capture)); // R4

  AST_SEL_NOT_FREERUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_FREERUN) |-> (ch_capture == '0)); // R3

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0)); // R2
endmodule

bind tmr_optreg tmr_optreg_chk u_chk (.*);

// File: tb/test_tmr_optreg.sv
`timescale 1ns/1ps
module test_tmr_optreg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        bit_wr_en = 1'b0;
  logic [2:0]  bit_wr_idx = '0;
  logic        bit_wr_val = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        cnt_en = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] count = '0;
  logic [1:0]  ch_capture;
  logic        ovf_flag;
  logic        ovf_irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model state
  logic        m_flag = 0, m_irq = 0;
  logic [1:0]  m_sel = 0;
  logic [15:0] m_prev = 0;

  localparam logic [2:0] FR = 3'b101, PW = 3'b110;

  always #4 clk = ~clk;

  tmr_optreg i_tmr_optreg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_wr_en(bit_wr_en), .bit_wr_idx(bit_wr_idx), .bit_wr_val(bit_wr_val),
    .rd_en(rd_en), .rd_data(rd_data), .cnt_en(cnt_en), .mode(mode),
    .count(count), .ch_capture(ch_capture), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  function automatic logic [7:0] exp_read();
    return rd_en ? {2'b00, m_sel, 3'b000, m_flag} : 8'h00;
  endfunction

  function automatic logic [1:0] exp_cap();
    return (mode == FR) ? m_sel : 2'b00;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "rd_data", 16'(rd_data), 16'(exp_read()));
    chk(tag, "ch_capture", 16'(ch_capture), 16'(exp_cap()));
    chk(tag, "ovf_flag", 16'(ovf_flag), 16'(m_flag));
    chk(tag, "ovf_irq", 16'(ovf_irq), 16'(m_irq));
  endtask

  task automatic model_step();
    logic wrap, clr;
    wrap = cnt_en && (mode == FR || mode == PW) && m_prev == 16'hFFFF && count == 16'h0000;
    clr  = wr_en ? !wr_data[0] : (bit_wr_en && bit_wr_idx == 3'd0 && !bit_wr_val);
    if (!cnt_en)   m_flag = 1'b0;
    else if (wrap) m_flag = 1'b1;
    else if (clr)  m_flag = 1'b0;
    if (!cnt_en) begin
      if (wr_en) m_sel = wr_data[5:4];
      else if (bit_wr_en && bit_wr_idx == 3'd4) m_sel[0] = bit_wr_val;
      else if (bit_wr_en && bit_wr_idx == 3'd5) m_sel[1] = bit_wr_val;
    end
    m_irq  = wrap;
    m_prev = count;
  endtask

  // Inputs are set just after a falling edge; outputs judged at the next falling edge.
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    wr_en = 0; bit_wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_en = 1;
    #1 check_all("R1");

    // R2 and R3: write all ones while stopped in free-running mode
    mode = FR; wr_en = 1; wr_data = 8'hFF; tick("R2");
    chk("R2", "reserved bits", 16'(rd_data), 16'h0030);
    chk("R3", "capture in FR", 16'(ch_capture), 16'h3);
    mode = 3'b010; #1 chk("R3", "compare outside FR", 16'(ch_capture), 16'h0);
    tick("R3");
    rd_en = 0; #1 chk("R2", "read gated", 16'(rd_data), 16'h0);
    rd_en = 1;

    // R4: select writes ignored while running
    cnt_en = 1; mode = FR; wr_en = 1; wr_data = 8'h00; tick("R4");
    bit_wr_en = 1; bit_wr_idx = 3'd5; bit_wr_val = 0; tick("R4");
    chk("R4", "sel kept", 16'(ch_capture), 16'h3);

    // R5: wrap in free-running mode
    count = 16'hFFFF; tick("R5");
    count = 16'h0000; tick("R5");
    chk("R5", "irq on wrap", 16'(ovf_irq), 16'h1);
    count = 16'h0001; tick("R5");
    chk("R5", "irq one cycle", 16'(ovf_irq), 16'h0);
    // R7: reads do not clear
    repeat (3) tick("R7");
    chk("R7", "flag after reads", 16'(ovf_flag), 16'h1);
    // R8: write 1 no effect, write 0 clears
    wr_en = 1; wr_data = 8'h01; tick("R8");
    chk("R8", "write one", 16'(ovf_flag), 16'h1);
    bit_wr_en = 1; bit_wr_idx = 3'd0; bit_wr_val = 0; tick("R8");
    chk("R8", "write zero", 16'(ovf_flag), 16'h0);

    // R6: wrap in another mode does nothing
    mode = 3'b011; count = 16'hFFFF; tick("R6");
    count = 16'h0000; tick("R6");
    chk("R6", "no flag", 16'(ovf_flag), 16'h0);

    // R10: wrap collides with byte clear in pulse-width mode
    mode = PW; count = 16'hFFFF; tick("R10");
    count = 16'h0000; wr_en = 1; wr_data = 8'h00; tick("R10");
    chk("R10", "wrap beats byte clear", 16'(ovf_flag), 16'h1);
    count = 16'hFFFF; wr_en = 1; wr_data = 8'h00; tick("R10");
    count = 16'h0000; bit_wr_en = 1; bit_wr_idx = 3'd0; bit_wr_val = 0; tick("R10");
    chk("R10", "wrap beats bit clear", 16'(ovf_irq), 16'h1);

    // R9: disable clears
    cnt_en = 0; count = 16'h0005; tick("R9");
    chk("R9", "disable clears", 16'(ovf_flag), 16'h0);

    // R11: bit write targets one bit; byte write wins on collision
    mode = FR; bit_wr_en = 1; bit_wr_idx = 3'd4; bit_wr_val = 0; tick("R11");
    chk("R11", "bit write ch0", 16'(ch_capture), 16'h2);
    wr_en = 1; wr_data = 8'h10; bit_wr_en = 1; bit_wr_idx = 3'd5; bit_wr_val = 1; tick("R11");
    chk("R11", "byte wins", 16'(ch_capture), 16'h1);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      cnt_en = (r != 0);
      r = $urandom_range(0, 3);
      mode = (r == 0) ? FR : (r == 1) ? PW : 3'($urandom);
      r = $urandom_range(0, 3);
      if (count == 16'hFFFF && r != 0) count = 16'h0000;
      else if (r == 0) count = 16'hFFFF;
      else count = 16'($urandom);
      r = $urandom_range(0, 5);
      if (r == 0) begin wr_en = 1; wr_data = 8'($urandom); end
      if (r == 1 || r == 2) begin
        bit_wr_en = 1; bit_wr_idx = 3'($urandom); bit_wr_val = 1'($urandom);
      end
      rd_en = 1'($urandom);
      tick("R2/R3/R4/R5/R6/R8/R9/R10");
    end
    finish_run();
  end
endmodule